// File: doc/BRIEF.md
# Serial Transmitter with Line-Driver Enable Timing

This block sends one asynchronous serial character at a time on a single TX line and drives a driver-enable output for a half-duplex transceiver such as RS-485. Software places a character in a one-entry holding register through a write strobe. The block then raises the enable, waits a programmed lead time, and shifts out the frame least significant bit first. The frame is one low start bit, 7, 8 or 9 word bits, and one high stop bit. After the stop bit it holds the enable for a programmed lag time and then releases it.

Timing comes from a per-sample tick supplied from outside. Both the lead and lag times are counted in sample ticks. A bit lasts 16 ticks, or 8 ticks when the oversampling select is set. Parity can replace the top word bit. If a character is written while the lag time is running, the enable stays high, and the new character starts only after the lag has finished and a complete new lead time has passed.

The controller has four states: `ST_IDLE` (line high, enable low), `ST_LEAD` (enable high, waiting before the start bit), `ST_SHIFT` (frame bits on the line) and `ST_LAG` (enable high after the stop bit). It has these transitions:
- IDLE→LEAD or IDLE→SHIFT when a character is pending. It goes to SHIFT directly when the lead time is 0.
- LEAD→SHIFT when the lead count ends.
- SHIFT→LAG at the end of the stop bit when the lag time is non-zero.
- SHIFT→IDLE at the end of the stop bit when the lag is 0 and nothing is pending.
- SHIFT→LEAD or SHIFT→SHIFT at the end of the stop bit when the lag is 0 and a character is pending.
- LAG→IDLE when the lag count ends and nothing is pending.
- LAG→LEAD or LAG→SHIFT when the lag count ends and a character is pending.
- Any state→IDLE when the enable input is low.

Top module: `uart_de_tx`

## Requirements
- R1: `word_len` selects the number of word bits: 00 gives 8, 01 gives 9, 10 gives 7, and 11 gives 8. The frame is a 0 start bit, then the word bits least significant bit first, then a single 1 stop bit.
- R2: With `par_en`=1, the last word bit sent is a computed parity bit instead of the top data bit. The total number of ones in the word, including that bit, is even when `par_odd`=0 and odd when `par_odd`=1.
- R3: Each frame bit lasts 16 sample ticks when `ovs8`=0 and 8 sample ticks when `ovs8`=1.
- R4: `de_o` rises one clock after the write is registered, and the start bit begins exactly `de_lead` ticks later. When `de_lead` is 0, it begins in the same clock.
- R5: `de_o` falls exactly `de_lag` ticks after the end of the stop bit.
- R6: A character written while the lag is running keeps `de_o` high. Its start bit begins `de_lag` plus `de_lead` ticks after the previous stop bit ended.
- R7: Word length and parity settings are captured when a character starts. Changing them afterwards does not alter that character.
- R8: While `line_en`=0, `tx_o` is 1 from the next clock, and `de_o`, `tx_empty` and `tx_done` are 0. The character in flight and any pending character are discarded, and writes are ignored.
- R9: `tx_empty` is 0 in the clock after an enabled write. It returns to 1 when the character moves from the holding register into the shifter.
- R10: `tx_done` becomes 1 in the same clock that `de_o` falls with nothing pending. An enabled write clears it.
- R11: `tx_o` is 1 whenever `de_o` is 0. Clocks without `smp_tick` do not advance the lead, bit or lag timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_en | input | 1 | Block enable; low clears all activity and flags |
| smp_tick | input | 1 | One-clock pulse per sample period |
| word_len | input | 2 | Word length code |
| par_en | input | 1 | Parity insertion enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| ovs8 | input | 1 | Bit period select: 0 = 16 ticks, 1 = 8 ticks |
| de_lead | input | 5 | Ticks from enable rise to start bit |
| de_lag | input | 5 | Ticks from stop bit end to enable fall |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| tx_o | output | 1 | Serial line, idles high |
| de_o | output | 1 | Line-driver enable |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission finished and line released |

## Verification
The bench keeps the sample tick high, so one tick equals one clock. It samples on falling edges and counts them from well-defined events:
- The write edge: `tx_empty` falls and `de_o` is still low one sample later, and `de_o` rises one sample after that.
- The enable rise: the start bit appears after exactly `de_lead` samples.
- The start edge: each bit is read at the middle of its 16- or 8-sample period.
- The last midpoint: `de_o` falls, together with `tx_done`, half a bit plus `de_lag` samples later.

For a write during the lag, the expected start of the next character is counted from the write sample. For a disable, the line, enable and flags are checked one sample after the enable input drops.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LAG   = 2'd3
    } tx_state_t;

    localparam int WORD_MAX = 9;
    localparam int FRAME_W  = WORD_MAX + 2;

endpackage

// File: rtl/de_frame_build.sv
module de_frame_build
    import uart_de_pkg::*;
#(
    parameter int WORD_W = WORD_MAX,
    localparam int FW    = WORD_W + 2,
    localparam int IDX_W = $clog2(FW + 1)
) (
    input  logic [WORD_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic              par_on,
    input  logic              par_odd_sel,
    output logic [FW-1:0]     frame,
    output logic [IDX_W-1:0]  frame_bits
);
    int unsigned n_word;
    logic        par_bit;

    always_comb begin
        unique case (len_code)
            2'b01:   n_word = 9;
            2'b10:   n_word = 7;
            default: n_word = 8;
        endcase
        par_bit = par_odd_sel;
        for (int i = 0; i < WORD_W; i++) begin
            if (i + 1 < int'(n_word)) par_bit = par_bit ^ data[i];
        end
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < int'(n_word)) begin
                if (par_on && (i == int'(n_word) - 1)) frame[i+1] = par_bit;
                else                                   frame[i+1] = data[i];
            end
        end
        frame_bits = IDX_W'(n_word + 2);
    end
endmodule

// File: rtl/de_tick_count.sv
module de_tick_count #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx
    import uart_de_pkg::*;
#(
    parameter int TIME_W = 5,
    parameter int OVS_HI = 16,
    parameter int OVS_LO = 8,
    localparam int CNT_W = (TIME_W > $clog2(OVS_HI)) ? TIME_W : $clog2(OVS_HI),
    localparam int IDX_W = $clog2(FRAME_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_en,
    input  logic                smp_tick,
    input  logic [1:0]          word_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                ovs8,
    input  logic [TIME_W-1:0]   de_lead,
    input  logic [TIME_W-1:0]   de_lag,
    input  logic                wr_stb,
    input  logic [WORD_MAX-1:0] wr_data,
    output logic                tx_o,
    output logic                de_o,
    output logic                tx_empty,
    output logic                tx_done
);
    tx_state_t            state_q, state_d;
    logic [WORD_MAX-1:0]  hold_q;
    logic                 full_q;
    logic                 done_q;
    logic [FRAME_W-1:0]   shift_q;
    logic [IDX_W-1:0]     nbits_q;
    logic [IDX_W-1:0]     bit_idx_q;
    logic [CNT_W-1:0]     cnt;
    logic                 cnt_clr;
    logic                 load;
    logic                 advance;
    logic                 set_done;
    logic [FRAME_W-1:0]   frame_new;
    logic [IDX_W-1:0]     bits_new;

    logic [CNT_W-1:0] period_last;
    logic [CNT_W-1:0] lead_last;
    logic [CNT_W-1:0] lag_last;
    logic             lead_zero;
    logic             lag_zero;
    logic             bit_end;
    logic             last_bit;

    de_frame_build #(.WORD_W(WORD_MAX)) u_frame (
        .data        (hold_q),
        .len_code    (word_len),
        .par_on      (par_en),
        .par_odd_sel (par_odd),
        .frame       (frame_new),
        .frame_bits  (bits_new)
    );

    de_tick_count #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr || !line_en),
        .inc   (smp_tick),
        .count (cnt)
    );

    assign period_last = ovs8 ? CNT_W'(OVS_LO - 1) : CNT_W'(OVS_HI - 1);
    assign lead_last   = CNT_W'(de_lead) - 1'b1;
    assign lag_last    = CNT_W'(de_lag) - 1'b1;
    assign lead_zero   = (de_lead == '0);
    assign lag_zero    = (de_lag == '0);
    assign bit_end     = smp_tick && (cnt == period_last);
    assign last_bit    = (bit_idx_q == nbits_q - 1'b1);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        load     = 1'b0;
        advance  = 1'b0;
        set_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (full_q) begin
                    load    = 1'b1;
                    state_d = lead_zero ? ST_SHIFT : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (smp_tick && (cnt == lead_last)) begin
                    cnt_clr = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_end) begin
                    cnt_clr = 1'b1;
                    if (!last_bit) begin
                        advance = 1'b1;
                    end else if (!lag_zero) begin
                        state_d = ST_LAG;
                    end else if (full_q) begin
                        load    = 1'b1;
                        state_d = lead_zero ? ST_SHIFT : ST_LEAD;
                    end else begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_LAG: begin
                if (smp_tick && (cnt == lag_last)) begin
                    cnt_clr = 1'b1;
                    if (full_q) begin
                        load    = 1'b1;
                        state_d = lead_zero ? ST_SHIFT : ST_LEAD;
                    end else begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hold_q    <= '0;
            full_q    <= 1'b0;
            done_q    <= 1'b0;
            shift_q   <= '1;
            nbits_q   <= '0;
            bit_idx_q <= '0;
        end else if (!line_en) begin
            state_q   <= ST_IDLE;
            full_q    <= 1'b0;
            done_q    <= 1'b0;
            shift_q   <= '1;
            bit_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_stb) begin
                hold_q <= wr_data;
                full_q <= 1'b1;
            end else if (load) begin
                full_q <= 1'b0;
            end
            if (wr_stb)        done_q <= 1'b0;
            else if (set_done) done_q <= 1'b1;
            if (load) begin
                shift_q   <= frame_new;
                nbits_q   <= bits_new;
                bit_idx_q <= '0;
            end else if (advance) begin
                shift_q   <= {1'b1, shift_q[FRAME_W-1:1]};
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_o     = (state_q == ST_SHIFT) ? shift_q[0] : 1'b1;
        de_o     = (state_q != ST_IDLE);
        tx_empty = line_en && !full_q;
        tx_done  = done_q;
    end
endmodule

// File: rtl/uart_de_tx_chk.sv
module uart_de_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic line_en,
    input logic smp_tick,
    input logic wr_stb,
    input logic tx_o,
    input logic de_o,
    input logic tx_empty,
    input logic tx_done
);
    // R11
    tx_low_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_o |-> de_o);

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && !smp_tick && de_o) |=> ($stable(tx_o) && $stable(de_o)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (tx_o && !de_o && !tx_done));

    // R9
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && wr_stb) |=> (!tx_empty || !line_en));

    // R10
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !de_o);

    // R10
    done_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $fell(de_o));
endmodule

bind uart_de_tx uart_de_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_en  (line_en),
    .smp_tick (smp_tick),
    .wr_stb   (wr_stb),
    .tx_o     (tx_o),
    .de_o     (de_o),
    .tx_empty (tx_empty),
    .tx_done  (tx_done)
);

// File: tb/sim_uart_de_tx.sv
`timescale 1ns/1ps
module sim_uart_de_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_en = 1'b1;
    logic       smp_tick = 1'b1;
    logic [1:0] word_len = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       ovs8 = 1'b0;
    logic [4:0] de_lead = 5'd0;
    logic [4:0] de_lag = 5'd0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_o, de_o, tx_empty, tx_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_de_tx u0 (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .smp_tick(smp_tick),
        .word_len(word_len), .par_en(par_en), .par_odd(par_odd), .ovs8(ovs8),
        .de_lead(de_lead), .de_lag(de_lag), .wr_stb(wr_stb), .wr_data(wr_data),
        .tx_o(tx_o), .de_o(de_o), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int word_bits(input logic [1:0] code);
        if (code == 2'b01) return 9;
        if (code == 2'b10) return 7;
        return 8;
    endfunction

    function automatic logic [10:0] exp_frame(input logic [8:0] d, input logic [1:0] code,
                                              input logic pe, input logic po);
        logic [10:0] f;
        int n;
        logic p;
        n = word_bits(code);
        f = '1;
        f[0] = 1'b0;
        p = po;
        for (int i = 0; i < n - 1; i++) p = p ^ d[i];
        for (int i = 0; i < n; i++) f[i+1] = (pe && i == n - 1) ? p : d[i];
        f[n+1] = 1'b1;
        return f;
    endfunction

    // called at the negedge where tx first reads 0
    task automatic sample_frame(input logic [10:0] f, input int nb, input int p, input string tag);
        int bad = 0;
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (i > 0) repeat (p) @(negedge clk);
            if (tx_o !== f[i] || de_o !== 1'b1) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic run_char(input logic [8:0] d, input logic [1:0] code, input logic pe,
                            input logic po, input logic os, input int lead, input int lag,
                            input bit flip, input bit freeze);
        int k;
        int p;
        int nb;
        logic [10:0] f;
        @(negedge clk);
        word_len = code; par_en = pe; par_odd = po; ovs8 = os;
        de_lead = 5'(lead); de_lag = 5'(lag);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(tx_empty == 1'b0 && de_o == 1'b0, "R9 write pending", int'(tx_empty), 0);
        chk(tx_done == 1'b0, "R10 cleared by write", int'(tx_done), 0);
        @(negedge clk);
        chk(de_o == 1'b1, "R4 de rise", int'(de_o), 1);
        chk(tx_empty == 1'b1, "R9 moved to shifter", int'(tx_empty), 1);
        if (flip) begin
            par_odd = ~po; word_len = code ^ 2'b11; par_en = ~pe;
        end
        if (freeze && lead > 0) begin
            smp_tick = 1'b0;
            repeat (20) @(negedge clk);
            chk(tx_o == 1'b1 && de_o == 1'b1, "R11 no tick no progress", int'(tx_o), 1);
            smp_tick = 1'b1;
        end
        k = 0;
        while (tx_o === 1'b1 && k < 100) begin @(negedge clk); k++; end
        chk(k == lead, "R4 lead ticks", k, lead);
        p  = os ? 8 : 16;
        nb = word_bits(code) + 2;
        f  = exp_frame(d, code, pe, po);
        sample_frame(f, nb, p, flip ? "R7 frame captured" : (pe ? "R2 parity frame" : "R1 R3 frame"));
        k = 0;
        while (de_o === 1'b1 && k < 200) begin @(negedge clk); k++; end
        chk(k == p / 2 + lag, "R5 lag ticks", k, p / 2 + lag);
        chk(tx_done == 1'b1, "R10 done at release", int'(tx_done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        int p;
        int nb;
        bit dropped;
        logic [10:0] f;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R11, R9)
        chk(tx_o == 1'b1 && de_o == 1'b0, "R11 reset idle", int'(tx_o), 1);
        chk(tx_empty == 1'b1 && tx_done == 1'b0, "R9 reset flags", int'(tx_empty), 1);

        // directed corners
        run_char(9'h0A5, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0);      // R1 R4 zero lead
        run_char(9'h1C3, 2'b01, 1'b0, 1'b0, 1'b1, 3, 31, 0, 0);     // R1 nine bits, R3 by 8
        run_char(9'h07F, 2'b10, 1'b1, 1'b0, 1'b0, 31, 5, 0, 0);     // R2 even, seven bits
        run_char(9'h0B1, 2'b00, 1'b1, 1'b1, 1'b1, 7, 0, 0, 0);      // R2 odd
        run_char(9'h155, 2'b01, 1'b1, 1'b0, 1'b0, 4, 9, 1, 0);      // R7 settings change
        run_char(9'h03C, 2'b00, 1'b0, 1'b0, 1'b1, 6, 2, 0, 1);      // R11 tick freeze

        // R6: write during lag
        @(negedge clk);
        word_len = 2'b00; par_en = 1'b0; ovs8 = 1'b1; de_lead = 5'd6; de_lag = 5'd12;
        wr_stb = 1'b1; wr_data = 9'h0F0;
        @(negedge clk); wr_stb = 1'b0;
        @(negedge clk);
        k = 0;
        while (tx_o === 1'b1 && k < 100) begin @(negedge clk); k++; end
        repeat (10 * 8 + 3) @(negedge clk);
        wr_stb = 1'b1; wr_data = 9'h033;
        @(negedge clk); wr_stb = 1'b0;
        k = 0; dropped = 0;
        while (tx_o === 1'b1 && k < 100) begin
            @(negedge clk); k++;
            if (de_o !== 1'b1) dropped = 1;
        end
        chk(k == 12 + 6 - 4, "R6 restart after lag and lead", k, 14);
        chk(!dropped && tx_done == 1'b0, "R6 de held", int'(dropped), 0);
        f = exp_frame(9'h033, 2'b00, 1'b0, 1'b0);
        sample_frame(f, 10, 8, "R6 second frame");
        k = 0;
        while (de_o === 1'b1 && k < 200) begin @(negedge clk); k++; end
        chk(k == 4 + 12, "R5 lag after queued char", k, 16);

        // R8: disable while done, then mid-frame
        @(negedge clk); line_en = 1'b0;
        @(negedge clk);
        chk(tx_done == 1'b0 && tx_empty == 1'b0, "R8 flags cleared", int'(tx_done), 0);
        line_en = 1'b1; de_lead = 5'd2; de_lag = 5'd3; ovs8 = 1'b0;
        @(negedge clk); wr_stb = 1'b1; wr_data = 9'h0FF;
        @(negedge clk); wr_stb = 1'b0;
        repeat (40) @(negedge clk);
        line_en = 1'b0;
        @(negedge clk);
        chk(tx_o == 1'b1 && de_o == 1'b0, "R8 stop at once", int'(de_o), 0);
        chk(tx_empty == 1'b0 && tx_done == 1'b0, "R8 flags low", int'(tx_empty), 0);
        wr_stb = 1'b1; wr_data = 9'h011;
        @(negedge clk); wr_stb = 1'b0;
        line_en = 1'b1;
        dropped = 0;
        repeat (60) begin
            @(negedge clk);
            if (de_o !== 1'b0 || tx_o !== 1'b1) dropped = 1;
        end
        chk(!dropped && tx_empty == 1'b1, "R8 discarded and write ignored", int'(dropped), 0);

        // random characters
        for (int t = 0; t < 16; t++) begin
            run_char(9'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     int'($urandom % 32), int'($urandom % 32), 0, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule